// File: doc/BRIEF.md
# Configurable Parallel Prefix Adder

This block adds two WIDTH-bit operands and a carry-in. It returns a WIDTH-bit sum and a carry-out. The work is split into three stages. The first stage forms a per-bit generate/propagate pair. The second stage is a tree of prefix cells that merges those pairs into a carry for every bit position. The third stage turns the carries back into sum bits and the carry-out.

The carry-in takes part in the tree as its own lowest position. Its generate is the carry-in value and its propagate is zero, and the operand bits sit one position higher. An elaboration parameter selects how the tree is wired. The choices are Kogge-Stone, Brent-Kung, Han-Carlson and Sklansky. All four wirings compute the same sum; they differ only in depth, fanout and cell count.

A second parameter can place one register stage on the outputs. There is no streaming handshake: the adder accepts a new operand pair every cycle and never stalls. An unsupported width or topology code stops elaboration with an error.

Top module: `pfx_adder`

## Requirements
- R1: With TOPO=0 (Kogge-Stone), {cout_o, sum_o} equals a_i + b_i + cin_i as a (WIDTH+1)-bit unsigned value for every operand pair.
- R2: With TOPO=1 (Brent-Kung), the outputs equal the same arithmetic sum as in R1.
- R3: With TOPO=2 (Han-Carlson), the outputs equal the same arithmetic sum as in R1.
- R4: With TOPO=3 (Sklansky), the outputs equal the same arithmetic sum as in R1.
- R5: cin_i adds exactly one at the least significant bit, including when it travels through every bit: 0+0+1 gives 1, and all-ones + 0 + 1 gives a zero sum with cout_o=1.
- R6: cout_o is 1 exactly when the true sum is 2^WIDTH or larger; for example 0x8000+0x8000 at WIDTH=16 gives sum 0 and cout_o=1.
- R7: With REG_OUT=1, sum_o and cout_o change only at a rising clk edge. They show the result for the inputs present at that edge, and they hold between edges.
- R8: With REG_OUT=1, rst high at a rising edge forces sum_o and cout_o to 0 at that edge, whatever the inputs are.
- R9: With REG_OUT=0, the outputs follow the inputs with no clock dependency and are not affected by rst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset for the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry-out |

## Verification
The hardest cases are the ones where a carry must cross every level of the tree. Examples are an all-ones operand plus a carry-in, or alternating patterns whose generates and propagates interleave. Only these cases reach the longest span cells and the Han-Carlson even-position fix-up row. The stimulus table places these patterns next to zero, single-bit and top-bit cases. Random vectors are added after the table. Every vector goes to all four topologies at once, so a wiring fault in one tree shows up as a mismatch against a sum computed in the bench.

// File: rtl/pfx_add_pkg.sv
package pfx_add_pkg;

  localparam int TOPO_KOGGE    = 0;
  localparam int TOPO_BRENT    = 1;
  localparam int TOPO_HAN      = 2;
  localparam int TOPO_SKLANSKY = 3;

  // Number of combine rows for a tree over 2**k nodes.
  function automatic int level_count(int topo, int k);
    case (topo)
      TOPO_KOGGE:    return k;
      TOPO_BRENT:    return 2 * k - 1;
      TOPO_HAN:      return k + 1;
      TOPO_SKLANSKY: return k;
      default:       return 1;
    endcase
  endfunction

  // Lower node that node i merges with on row lvl, or -1 for a pass-through.
  function automatic int partner(int topo, int k, int lvl, int i);
    int s;
    int d;
    case (topo)
      TOPO_KOGGE: begin
        s = 1 << lvl;
        return (i >= s) ? i - s : -1;
      end
      TOPO_SKLANSKY: begin
        return (((i >> lvl) & 1) == 1) ? ((i >> lvl) << lvl) - 1 : -1;
      end
      TOPO_BRENT: begin
        if (lvl < k) begin
          s = 1 << lvl;
          return (((i + 1) % (2 * s)) == 0) ? i - s : -1;
        end
        d = k - 2 - (lvl - k);
        s = 1 << d;
        return ((((i + 1) % (2 * s)) == s) && (i + 1 > s)) ? i - s : -1;
      end
      TOPO_HAN: begin
        if (lvl == 0) return ((i % 2) == 1) ? i - 1 : -1;
        if (lvl == k) return (((i % 2) == 0) && (i >= 2)) ? i - 1 : -1;
        s = 1 << lvl;
        return (((i % 2) == 1) && (i >= s + 1)) ? i - s : -1;
      end
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/pfx_pg_stage.sv
module pfx_pg_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   g_o,
  output logic [WIDTH:0]   p_o
);
  // Position 0 carries the carry-in, operand bits sit at 1..WIDTH.
  assign g_o = {a_i & b_i, cin_i};
  assign p_o = {a_i ^ b_i, 1'b0};
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
  parameter int N    = 16,
  parameter int TOPO = 0
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] carry_o
);
  localparam int K  = $clog2(N);
  localparam int LV = pfx_add_pkg::level_count(TOPO, K);

  logic [N-1:0] gl [LV+1];
  logic [N-1:0] pl [LV+1];

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int J = pfx_add_pkg::partner(TOPO, K, lv, i);
      if (J >= 0) begin : g_cell
        assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
        assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
      end else begin : g_pass
        assign gl[lv+1][i] = gl[lv][i];
        assign pl[lv+1][i] = pl[lv][i];
      end
    end
  end

  assign carry_o = gl[LV];

  // Independent serial carry chain, used only by the checks below.
  logic [N-1:0] ripple;
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < N; i++) begin
      c = g_i[i] | (p_i[i] & c);
      ripple[i] = c;
    end
    // R1: every tree carry equals the serial carry chain.
    assert_tree_matches_ripple_R1: assert (carry_o == ripple)
      else $error("prefix carries %h differ from ripple %h", carry_o, ripple);
    // R1: each finished group reaches position 0, whose propagate is zero.
    assert_prefix_span_R1: assert (pl[LV] == '0)
      else $error("some group does not span down to position 0: %h", pl[LV]);
  end
endmodule

// File: rtl/pfx_sum_stage.sv
module pfx_sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0]   g_i,
  input  logic [WIDTH:0]   p_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  // carry_i[k] is the carry into operand bit k (prefix of positions k..0).
  assign sum_o  = p_i[WIDTH:1] ^ carry_i;
  assign cout_o = g_i[WIDTH] | (p_i[WIDTH] & carry_i[WIDTH-1]);
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int WIDTH   = 16,
  parameter int TOPO    = 0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  if ((WIDTH < 4) || (WIDTH > 64) || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_width
    $error("WIDTH must be a power of two from 4 to 64");
  end
  if ((TOPO < pfx_add_pkg::TOPO_KOGGE) || (TOPO > pfx_add_pkg::TOPO_SKLANSKY)) begin : g_bad_topo
    $error("TOPO selects an unsupported prefix network");
  end

  logic [WIDTH:0]   g_bit;
  logic [WIDTH:0]   p_bit;
  logic [WIDTH-1:0] carry;
  logic [WIDTH-1:0] sum_raw;
  logic             cout_raw;
  logic [WIDTH:0]   ref_total;

  pfx_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .g_o(g_bit), .p_o(p_bit)
  );

  pfx_tree #(.N(WIDTH), .TOPO(TOPO)) u_tree (
    .g_i(g_bit[WIDTH-1:0]), .p_i(p_bit[WIDTH-1:0]), .carry_o(carry)
  );

  pfx_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .g_i(g_bit), .p_i(p_bit), .carry_i(carry), .sum_o(sum_raw), .cout_o(cout_raw)
  );

  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_raw;
        cout_o <= cout_raw;
      end
    end

    assert_reg_latency_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({cout_o, sum_o} == $past(ref_total)));

    assert_sync_reset_R8: assert property (@(posedge clk)
      rst |=> ((sum_o == '0) && !cout_o));
  end else begin : g_comb
    assign sum_o  = sum_raw;
    assign cout_o = cout_raw;

    always_comb begin
      assert_comb_sum_R9: assert ({cout_o, sum_o} == ref_total)
        else $error("combinational sum mismatch");
    end
  end
endmodule

// File: tb/pfx_adder_tb.sv
module pfx_adder_tb;
  localparam int W      = 16;
  localparam int CLK_NS = 8;
  localparam int NVEC   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic cin = 1'b0;

  logic [W-1:0] ks_s, bk_s, hc_s, sk_s, cb_s;
  logic ks_c, bk_c, hc_c, sk_c, cb_c;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2) clk = ~clk;

  pfx_adder #(.WIDTH(W), .TOPO(0), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(ks_s), .cout_o(ks_c));
  pfx_adder #(.WIDTH(W), .TOPO(1), .REG_OUT(1'b1)) u_bk (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(bk_s), .cout_o(bk_c));
  pfx_adder #(.WIDTH(W), .TOPO(2), .REG_OUT(1'b1)) u_hc (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(hc_s), .cout_o(hc_c));
  pfx_adder #(.WIDTH(W), .TOPO(3), .REG_OUT(1'b1)) u_sk (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sk_s), .cout_o(sk_c));
  pfx_adder #(.WIDTH(W), .TOPO(3), .REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(cb_s), .cout_o(cb_c));

  // {a, b, cin, expected cout+sum}
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'h5555, 16'h5555, 1'b0, 17'h0AAAA},
    {16'hAAAA, 16'hAAAA, 1'b1, 17'h15555},
    {16'h8000, 16'h8000, 1'b0, 17'h10000},
    {16'h1234, 16'h4321, 1'b1, 17'h05556},
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000}
  };

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input logic [W:0] exp);
    chk("R1 kogge-stone", {ks_c, ks_s}, exp);
    chk("R2 brent-kung",  {bk_c, bk_s}, exp);
    chk("R3 han-carlson", {hc_c, hc_s}, exp);
    chk("R4 sklansky",    {sk_c, sk_s}, exp);
    chk("R9 comb path",   {cb_c, cb_s}, exp);
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                       input logic cv);
    return {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL R7 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset holds registered outputs at zero despite busy inputs.
    a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 reset kogge", {ks_c, ks_s}, '0);
    chk("R8 reset sklansky", {sk_c, sk_s}, '0);
    chk("R9 comb during reset", {cb_c, cb_s}, 17'h1FFFF);
    rst = 1'b0;

    // Table walk: every topology against precomputed results.
    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][49:34], VEC[k][33:18], VEC[k][17]);
      check_all(VEC[k][16:0]);
    end

    // R5: carry-in at the bottom position.
    apply(16'h0000, 16'h0000, 1'b1);
    chk("R5 cin only", {ks_c, ks_s}, 17'h00001);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R5 cin through all bits", {hc_c, hc_s}, 17'h10000);
    chk("R5 cin through all bits bk", {bk_c, bk_s}, 17'h10000);

    // R6: carry-out boundaries.
    apply(16'h8000, 16'h8000, 1'b0);
    chk("R6 top bit overflow", {sk_c, sk_s}, 17'h10000);
    apply(16'hFFFF, 16'h0000, 1'b0);
    chk("R6 no overflow at max", {ks_c, ks_s}, 17'h0FFFF);

    // R7: registered outputs move only at the rising edge.
    @(negedge clk);
    a = 16'h0F0F; b = 16'h00F1; cin = 1'b0;
    #2;
    chk("R7 hold before edge", {ks_c, ks_s}, 17'h0FFFF);
    chk("R9 comb follows at once", {cb_c, cb_s}, 17'h01000);
    @(negedge clk);
    chk("R7 update after edge", {ks_c, ks_s}, 17'h01000);

    // R8: mid-run synchronous reset.
    @(negedge clk);
    a = 16'h1234; b = 16'h1111; cin = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R8 mid-run reset", {hc_c, hc_s}, '0);
    chk("R8 reset bk", {bk_c, bk_s}, '0);
    chk("R9 comb ignores reset", {cb_c, cb_s}, 17'h02345);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 resume after reset", {hc_c, hc_s}, 17'h02345);

    // Random operands across all topologies.
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc);
      check_all(model(ra, rb, rc));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule